// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular queue of in-flight instructions that lets results arrive in any order while architectural state changes strictly in program order. Each issued instruction is given a slot. The slot number goes back to the issue logic as a tag, and reservation stations use it to name the pending result. Execution units later broadcast a tag with its result, and the matching slot is marked ready. The oldest slot retires once its result is present. A register operation writes the register file, a store is released to memory with its address and data together, and a branch is checked for misprediction.

The issue, result-broadcast, retirement and redirect ports stand in for the scheduler, functional units and memory system. When a mispredicted branch reaches the oldest position, every slot is discarded, the queue returns to empty, and the correct successor address is driven to fetch for one cycle.

Top module: `rob_core`

## Requirements
- R1: After reset the queue is empty: `iss_ready` is 1, `iss_tag` is 0, and `commit_valid`, `rf_we`, `mem_we` and `redirect_valid` are all 0.
- R2: An accepted issue (`iss_valid` and `iss_ready` both 1 at a clock edge) allocates the slot shown on `iss_tag` before that edge. Successive tags count up by one and wrap from DEPTH-1 to 0.
- R3: Once DEPTH slots are occupied, `iss_ready` is 0. An issue request while `iss_ready` is 0 is ignored, and `iss_tag` does not move.
- R4: A broadcast with `cdb_valid` writes `cdb_value`, `cdb_addr` and `cdb_mispredict` into the occupied slot named by `cdb_tag` and marks it ready. Younger slots that become ready before the oldest one do not retire.
- R5: Retirement happens only at the oldest slot, only when it is ready, at most once per cycle and in allocation order. `commit_tag` names the retiring slot.
- R6: A retiring register operation (`iss_kind` 2'b00) asserts `rf_we` with `rf_waddr` equal to its issued register number and `rf_wdata` equal to its broadcast value. Nothing is written to memory.
- R7: A retiring store (`iss_kind` 2'b01) asserts `mem_we` with `mem_addr` and `mem_wdata` equal to the address and value captured at its broadcast. No register is written.
- R8: A retiring branch (`iss_kind` 2'b10) that was predicted correctly (`cdb_mispredict` 0) changes no register or memory state and causes no redirect.
- R9: A retiring branch with `cdb_mispredict` 1 leaves the queue empty in the next cycle (`iss_tag` 0, `iss_ready` 1). `redirect_valid` is high for exactly that one cycle, and `redirect_pc` equals the branch's broadcast value, which is its correct successor address. Younger slots never retire, and an issue in the retiring cycle is dropped.
- R10: An allocation and a retirement in the same cycle leave the occupancy unchanged.
- R11: A broadcast naming a slot that is not occupied is ignored. A later allocation of that slot starts not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | Instruction kind: 00 register op, 01 store, 10 branch |
| iss_reg | input | REG_W | Destination register number (register ops) |
| iss_ready | output | 1 | A free slot exists |
| iss_tag | output | TAG_W | Slot that the next accepted issue receives |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Slot the broadcast belongs to |
| cdb_value | input | XLEN | Result, store data, or branch successor address |
| cdb_addr | input | XLEN | Store address |
| cdb_mispredict | input | 1 | Branch was mispredicted |
| commit_valid | output | 1 | Oldest slot retires this cycle |
| commit_tag | output | TAG_W | Retiring slot |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | REG_W | Register file write index |
| rf_wdata | output | XLEN | Register file write data |
| mem_we | output | 1 | Store release to memory |
| mem_addr | output | XLEN | Store address |
| mem_wdata | output | XLEN | Store data |
| redirect_valid | output | 1 | Flush and fetch redirect, one cycle |
| redirect_pc | output | XLEN | Correct successor address for fetch |

## Verification
On every cycle the assertions check the occupancy bookkeeping: the count never passes DEPTH, it moves by allocations minus retirements, a refused issue leaves the tag in place, tags step with wrap-around, and a state write only happens with a retirement. They also check that a redirect is a single-cycle pulse that leaves the queue empty. The bench scenarios cover what depends on data and ordering. These are out-of-order completion held back behind an unready oldest slot, the exact register and memory values released, a correct branch retiring silently, younger work discarded after a misprediction, and a stray broadcast to a free slot having no effect on its later occupant.

// File: rtl/rob_pkg.sv
// Shared types for the reorder buffer.
// Assumes: kind encodings are fixed because the issue port carries them raw.
package rob_pkg;
    typedef enum logic [1:0] {
        KIND_REG    = 2'b00,
        KIND_STORE  = 2'b01,
        KIND_BRANCH = 2'b10
    } op_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
// Head/tail/occupancy control for the circular slot array.
// Assumes: the caller never allocates when full nor retires when empty;
// a flush overrides both and empties the queue.
module rob_ptrs #(
    parameter int DEPTH = 8,
    parameter int TAG_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             retire,
    input  logic             flush,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    function automatic logic [TAG_W-1:0] step(input logic [TAG_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Advance pointers and occupancy; flush returns everything to empty.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (alloc)  tail <= step(tail);
            if (retire) head <= step(head);
            count <= count + CNT_W'(alloc) - CNT_W'(retire);
        end
    end

    // Full when every slot is occupied.
    always_comb full = (count == CAP);
endmodule

// File: rtl/rob_entries.sv
// Slot storage: one register set per slot, written on allocation and on
// result broadcast, with a read port at the retirement index.
// Assumes: allocation and freeing never target the same slot in one cycle
// except through flush, which clears every slot.
module rob_entries
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32,
    parameter int REG_W = 5,
    parameter int TAG_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             alloc,
    input  logic [TAG_W-1:0] alloc_idx,
    input  op_kind_e         alloc_kind,
    input  logic [REG_W-1:0] alloc_reg,
    input  logic             cdb_valid,
    input  logic [TAG_W-1:0] cdb_tag,
    input  logic [XLEN-1:0]  cdb_value,
    input  logic [XLEN-1:0]  cdb_addr,
    input  logic             cdb_mispredict,
    input  logic             free,
    input  logic [TAG_W-1:0] rd_idx,
    output logic             rd_live,
    output logic             rd_ready,
    output op_kind_e         rd_kind,
    output logic [REG_W-1:0] rd_reg,
    output logic [XLEN-1:0]  rd_value,
    output logic [XLEN-1:0]  rd_addr,
    output logic             rd_mispredict
);
    logic             live_v   [DEPTH];
    logic             ready_v  [DEPTH];
    op_kind_e         kind_v   [DEPTH];
    logic [REG_W-1:0] reg_v    [DEPTH];
    logic [XLEN-1:0]  value_v  [DEPTH];
    logic [XLEN-1:0]  addr_v   [DEPTH];
    logic             misp_v   [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [TAG_W-1:0] MY = TAG_W'(i);
        logic             live_q, ready_q, misp_q;
        op_kind_e         kind_q;
        logic [REG_W-1:0] reg_q;
        logic [XLEN-1:0]  value_q, addr_q;

        // Slot life cycle: allocate, capture result, free at retirement.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q  <= 1'b0;
                ready_q <= 1'b0;
                misp_q  <= 1'b0;
                kind_q  <= KIND_REG;
                reg_q   <= '0;
                value_q <= '0;
                addr_q  <= '0;
            end else if (flush) begin
                live_q  <= 1'b0;
                ready_q <= 1'b0;
            end else begin
                if (free && rd_idx == MY) begin
                    live_q  <= 1'b0;
                    ready_q <= 1'b0;
                end
                if (alloc && alloc_idx == MY) begin
                    live_q  <= 1'b1;
                    ready_q <= 1'b0;
                    misp_q  <= 1'b0;
                    kind_q  <= alloc_kind;
                    reg_q   <= alloc_reg;
                end else if (cdb_valid && cdb_tag == MY && live_q) begin
                    ready_q <= 1'b1;
                    value_q <= cdb_value;
                    addr_q  <= cdb_addr;
                    misp_q  <= cdb_mispredict;
                end
            end
        end

        assign live_v[i]  = live_q;
        assign ready_v[i] = ready_q;
        assign kind_v[i]  = kind_q;
        assign reg_v[i]   = reg_q;
        assign value_v[i] = value_q;
        assign addr_v[i]  = addr_q;
        assign misp_v[i]  = misp_q;
    end

    // Read port at the retirement index.
    always_comb begin
        rd_live       = live_v[rd_idx];
        rd_ready      = ready_v[rd_idx];
        rd_kind       = kind_v[rd_idx];
        rd_reg        = reg_v[rd_idx];
        rd_value      = value_v[rd_idx];
        rd_addr       = addr_v[rd_idx];
        rd_mispredict = misp_v[rd_idx];
    end
endmodule

// File: rtl/rob_retire.sv
// Retirement decode: turns the oldest slot into one architectural action.
// Assumes: slot fields are stable for the whole cycle (registered upstream).
module rob_retire
    import rob_pkg::*;
(
    input  logic     head_live,
    input  logic     head_ready,
    input  op_kind_e head_kind,
    input  logic     head_mispredict,
    output logic     retire,
    output logic     rf_we,
    output logic     mem_we,
    output logic     flush_req
);
    // Decide whether the oldest slot leaves and what it does.
    always_comb begin
        retire    = head_live && head_ready;
        rf_we     = retire && (head_kind == KIND_REG);
        mem_we    = retire && (head_kind == KIND_STORE);
        flush_req = retire && (head_kind == KIND_BRANCH) && head_mispredict;
    end
endmodule

// File: rtl/rob_core.sv
// Reorder buffer top: allocates slots in program order, collects results in
// any order, retires the oldest ready slot each cycle and raises a one-cycle
// redirect when a mispredicted branch retires.
// Assumes: DEPTH >= 2; broadcasts name slots handed out by iss_tag.
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32,
    parameter int REG_W = 5,
    parameter int TAG_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [1:0]       iss_kind,
    input  logic [REG_W-1:0] iss_reg,
    output logic             iss_ready,
    output logic [TAG_W-1:0] iss_tag,
    input  logic             cdb_valid,
    input  logic [TAG_W-1:0] cdb_tag,
    input  logic [XLEN-1:0]  cdb_value,
    input  logic [XLEN-1:0]  cdb_addr,
    input  logic             cdb_mispredict,
    output logic             commit_valid,
    output logic [TAG_W-1:0] commit_tag,
    output logic             rf_we,
    output logic [REG_W-1:0] rf_waddr,
    output logic [XLEN-1:0]  rf_wdata,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    output logic             redirect_valid,
    output logic [XLEN-1:0]  redirect_pc
);
    logic [TAG_W-1:0] head, tail;
    logic [CNT_W-1:0] count;
    logic             full, alloc, retire, flush_req;
    logic             h_live, h_ready, h_misp;
    op_kind_e         h_kind;
    logic [REG_W-1:0] h_reg;
    logic [XLEN-1:0]  h_value, h_addr;

    // Accept an issue whenever a slot is free.
    always_comb alloc = iss_valid && !full;

    rob_ptrs #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .alloc(alloc), .retire(retire),
        .flush(flush_req), .head(head), .tail(tail), .count(count), .full(full)
    );

    rob_entries #(.DEPTH(DEPTH), .XLEN(XLEN), .REG_W(REG_W), .TAG_W(TAG_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .flush(flush_req),
        .alloc(alloc), .alloc_idx(tail), .alloc_kind(op_kind_e'(iss_kind)),
        .alloc_reg(iss_reg),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .cdb_addr(cdb_addr), .cdb_mispredict(cdb_mispredict),
        .free(retire), .rd_idx(head),
        .rd_live(h_live), .rd_ready(h_ready), .rd_kind(h_kind), .rd_reg(h_reg),
        .rd_value(h_value), .rd_addr(h_addr), .rd_mispredict(h_misp)
    );

    rob_retire u_retire (
        .head_live(h_live), .head_ready(h_ready), .head_kind(h_kind),
        .head_mispredict(h_misp), .retire(retire), .rf_we(rf_we),
        .mem_we(mem_we), .flush_req(flush_req)
    );

    // Drive issue and retirement data ports from the pointer and head slot.
    always_comb begin
        iss_ready    = !full;
        iss_tag      = tail;
        commit_valid = retire;
        commit_tag   = head;
        rf_waddr     = h_reg;
        rf_wdata     = h_value;
        mem_addr     = h_addr;
        mem_wdata    = h_value;
    end

    // Register the redirect pulse and its target address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= flush_req;
            if (flush_req) redirect_pc <= h_value;
        end
    end
endmodule

// File: rtl/rob_checker.sv
// Protocol checker for rob_core, attached with bind below.
// Assumes: sampled on the design clock; all properties masked during reset.
module rob_checker #(
    parameter int DEPTH = 8,
    parameter int TAG_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic [TAG_W-1:0] iss_tag,
    input logic             commit_valid,
    input logic             rf_we,
    input logic             mem_we,
    input logic             redirect_valid,
    input logic [CNT_W-1:0] count
);
    logic [TAG_W-1:0] nxt_q;

    // Remember the wrapped successor of the current tag.
    always_ff @(posedge clk)
        nxt_q <= (iss_tag == TAG_W'(DEPTH - 1)) ? '0 : iss_tag + 1'b1;

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    a_r3_refused_issue_holds_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> (iss_tag == $past(iss_tag)) || redirect_valid);

    a_r2_tag_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> (iss_tag == nxt_q) || redirect_valid);

    a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> redirect_valid ||
            (int'(count) == int'($past(count)) + int'($past(iss_valid && iss_ready))
                                               - int'($past(commit_valid))));

    a_r6_write_needs_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || mem_we) |-> (commit_valid && count != '0));

    a_r9_redirect_single: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    a_r9_redirect_empties: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (count == '0 && iss_tag == '0 && !commit_valid));
endmodule

bind rob_core rob_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_tag(iss_tag), .commit_valid(commit_valid), .rf_we(rf_we),
    .mem_we(mem_we), .redirect_valid(redirect_valid), .count(count)
);

// File: tb/sim_rob_core.sv
// Scoreboard bench: the driver records each allocated tag and its expected
// retirement action; the monitor pops and compares on every retirement.
module sim_rob_core;
    import rob_pkg::*;
    localparam int DEPTH = 8;
    localparam int XLEN  = 32;
    localparam int REG_W = 5;
    localparam int TAG_W = 3;

    logic clk, rst_n;
    logic iss_valid, iss_ready;
    logic [1:0] iss_kind;
    logic [REG_W-1:0] iss_reg;
    logic [TAG_W-1:0] iss_tag, cdb_tag, commit_tag;
    logic cdb_valid, cdb_mispredict, commit_valid, rf_we, mem_we, redirect_valid;
    logic [XLEN-1:0] cdb_value, cdb_addr, rf_wdata, mem_addr, mem_wdata, redirect_pc;
    logic [REG_W-1:0] rf_waddr;

    rob_core #(.DEPTH(DEPTH), .XLEN(XLEN), .REG_W(REG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_kind(iss_kind),
        .iss_reg(iss_reg), .iss_ready(iss_ready), .iss_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .cdb_addr(cdb_addr), .cdb_mispredict(cdb_mispredict),
        .commit_valid(commit_valid), .commit_tag(commit_tag), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0, commits = 0, flushes = 0;
    op_kind_e exp_kind [DEPTH];
    logic [REG_W-1:0] exp_reg [DEPTH];
    logic [XLEN-1:0] exp_val [DEPTH], exp_addr [DEPTH];
    logic [TAG_W-1:0] pend_q [$];
    logic [TAG_W-1:0] mon_t;
    bit flush_armed = 0;
    logic [XLEN-1:0] exp_pc = '0;

    function automatic void chk(string req, string what, longint unsigned act,
                                longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endfunction

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic issue(op_kind_e k, logic [REG_W-1:0] r, output logic [TAG_W-1:0] t);
        chk("R3", "ready before issue", iss_ready, 1);
        t = iss_tag;
        iss_valid = 1'b1; iss_kind = k; iss_reg = r;
        exp_kind[t] = k; exp_reg[t] = r;
        pend_q.push_back(t);
        tick(1);
        iss_valid = 1'b0;
    endtask

    task automatic complete(logic [TAG_W-1:0] t, logic [XLEN-1:0] v,
                            logic [XLEN-1:0] a, logic m);
        exp_val[t] = v; exp_addr[t] = a;
        if (exp_kind[t] == KIND_BRANCH && m) begin flush_armed = 1; exp_pc = v; end
        cdb_valid = 1'b1; cdb_tag = t; cdb_value = v; cdb_addr = a; cdb_mispredict = m;
        tick(1);
        cdb_valid = 1'b0; cdb_mispredict = 1'b0;
    endtask

    // Monitor: compare each retirement and redirect with the scoreboard.
    always @(negedge clk) if (rst_n) begin
        if (commit_valid) begin
            commits++;
            if (pend_q.size() == 0) chk("R5", "unexpected retirement", 1, 0);
            else begin
                mon_t = pend_q.pop_front();
                chk("R5", "retire order tag", commit_tag, mon_t);
                case (exp_kind[mon_t])
                    KIND_REG: begin
                        chk("R6", "rf_we", rf_we, 1);
                        chk("R6", "rf_waddr", rf_waddr, exp_reg[mon_t]);
                        chk("R6", "rf_wdata", rf_wdata, exp_val[mon_t]);
                        chk("R6", "mem_we", mem_we, 0);
                    end
                    KIND_STORE: begin
                        chk("R7", "mem_we", mem_we, 1);
                        chk("R7", "mem_addr", mem_addr, exp_addr[mon_t]);
                        chk("R7", "mem_wdata", mem_wdata, exp_val[mon_t]);
                        chk("R7", "rf_we", rf_we, 0);
                    end
                    default: chk("R8", "branch writes", {rf_we, mem_we}, 0);
                endcase
            end
        end else if (rf_we || mem_we) chk("R6", "write without retirement", 1, 0);
        if (redirect_valid) begin
            flushes++;
            chk("R9", "redirect expected", flush_armed, 1);
            chk("R9", "redirect_pc", redirect_pc, exp_pc);
            flush_armed = 0;
            pend_q.delete();
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [TAG_W-1:0] t;
        logic [TAG_W-1:0] tg [DEPTH];
        rst_n = 0; iss_valid = 0; iss_kind = 0; iss_reg = 0;
        cdb_valid = 0; cdb_tag = 0; cdb_value = 0; cdb_addr = 0; cdb_mispredict = 0;
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        chk("R1", "iss_ready", iss_ready, 1);
        chk("R1", "iss_tag", iss_tag, 0);
        chk("R1", "outputs idle", {commit_valid, rf_we, mem_we, redirect_valid}, 0);

        // R2 tags in order; R4 out-of-order completion held back
        for (int i = 0; i < 3; i++) begin
            issue(KIND_REG, REG_W'(i + 3), tg[i]);
            chk("R2", "tag", tg[i], i);
        end
        complete(tg[2], 32'hA2, 0, 0);
        complete(tg[1], 32'hA1, 0, 0);
        tick(2);
        chk("R4", "no retirement before oldest ready", commits, 0);
        complete(tg[0], 32'hA0, 0, 0);
        tick(4);
        chk("R5", "three in order", commits, 3);

        // R7 store
        issue(KIND_STORE, 0, t);
        complete(t, 32'hCAFE, 32'h100, 0);
        tick(2);
        // R8 correct branch
        issue(KIND_BRANCH, 0, t);
        complete(t, 32'h44, 0, 0);
        tick(2);
        chk("R8", "no redirect", flushes, 0);
        chk("R8", "branch retired", commits, 5);

        // R3 fill to full, R2 wrap
        for (int i = 0; i < DEPTH; i++) issue(KIND_REG, REG_W'(i + 10), tg[i]);
        chk("R2", "wrap to zero", tg[3], 0);
        chk("R3", "full blocks", iss_ready, 0);
        iss_valid = 1; iss_kind = KIND_REG; iss_reg = 5'd31;
        tick(1);
        iss_valid = 0;
        chk("R3", "refused issue keeps tag", iss_tag, tg[0]);
        chk("R3", "still full", iss_ready, 0);
        for (int i = 0; i < DEPTH; i++) complete(tg[i], 32'h100 + i, 0, 0);
        tick(3);
        chk("R5", "drained", commits, 13);
        chk("R3", "ready after drain", iss_ready, 1);

        // R10 simultaneous allocate and retire
        for (int i = 0; i < DEPTH - 1; i++) issue(KIND_REG, REG_W'(i + 1), tg[i]);
        complete(tg[0], 32'h200, 0, 0);
        issue(KIND_REG, 5'd20, tg[DEPTH - 1]);
        chk("R10", "occupancy unchanged", iss_ready, 1);
        issue(KIND_REG, 5'd21, tg[0]);
        chk("R10", "now full", iss_ready, 0);
        for (int i = 1; i < DEPTH; i++) complete(tg[i], 32'h300 + i, 0, 0);
        complete(tg[0], 32'h3FF, 0, 0);
        tick(3);
        chk("R10", "all retired", commits, 22);

        // R9 mispredicted branch flushes younger work
        issue(KIND_BRANCH, 0, tg[0]);
        issue(KIND_REG, 5'd7, tg[1]);
        complete(tg[1], 32'h77, 0, 0);
        complete(tg[0], 32'h1234_0000, 0, 1);
        tick(4);
        chk("R9", "one redirect", flushes, 1);
        chk("R9", "only branch retired", commits, 23);
        chk("R9", "tag reset", iss_tag, 0);
        chk("R9", "empty", iss_ready, 1);

        // R11 broadcast to a free slot ignored
        issue(KIND_REG, 5'd9, tg[0]);
        cdb_valid = 1; cdb_tag = 3; cdb_value = 32'hBAD; cdb_addr = 0;
        tick(1);
        cdb_valid = 0;
        for (int i = 1; i < 4; i++) issue(KIND_REG, REG_W'(i + 12), tg[i]);
        chk("R11", "slot three allocated", tg[3], 3);
        for (int i = 0; i < 3; i++) complete(tg[i], 32'h400 + i, 0, 0);
        tick(6);
        chk("R11", "slot three not ready", commits, 26);
        complete(tg[3], 32'h33, 0, 0);
        tick(3);
        chk("R11", "slot three retired", commits, 27);
        chk("R5", "scoreboard empty", pend_q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule